// File: doc/BRIEF.md
# Lockable Retained Configuration Bank

This block holds a small bank of configuration words that boot software programs through a plain register write port. When a trusted agent pulses its lock input, the bank freezes. From then on every ordinary write is refused and flagged. The lock and the stored words are kept across light sleep, warm reset and hibernate entry. A cold power-on reset is the only event that returns the bank to its default contents.

When the power-state input reports a hibernate resume, a restore window opens. While the window is open, a separate trusted port can reload whole words whatever the lock says. Ordinary writes are refused for as long as the window is open. A restore-complete pulse from the trusted agent closes the window and loads the saved lock value. The window also closes if the power state leaves the resume code.

At cold reset every word comes up all ones, which is the restrictive setting for the peripherals these words guard. The bank therefore never starts in an open configuration. Reads of the words and of a status word are allowed at all times and return one cycle later.

Top module: `cfg_lock_bank`

## Requirements
- R1: After cold reset (rst_n low), every register reads all ones, the status word reads zero, and both rd_valid and viol are 0.
- R2: With the lock clear and the window closed, a write to address a (0..3) replaces exactly the bytes of that register whose bit is set in wr_be; bit k of wr_be covers data bits 8k+7..8k, and the other bytes are kept.
- R3: Once lock_set has been sampled high, ordinary writes leave every register unchanged.
- R4: An ordinary write issued while the lock is set or the window is open raises viol in the cycle after the attempt. An accepted write leaves viol low.
- R5: Ordinary writes, lock_set and the power-state codes never clear the lock. Only a cold reset or a completed restore (R9) can clear it.
- R6: The power-state codes 1 (sleep), 2 (warm reset) and 3 (hibernate entry) leave the lock, the window and all register contents unchanged.
- R7: The window opens at the first clock edge at which pwr_state reads 4 (hibernate resume) after having read another code. It stays open while the code stays 4, and it closes on rs_done or when the code changes. Status bit 1 shows whether the window is open.
- R8: A restore write (rs_en) while the window is open replaces the whole word at rs_addr, even when the lock is set. A restore write outside the window changes nothing and raises viol in the next cycle.
- R9: An rs_done pulse while the window is open sets the lock to rs_lock, ORed with lock_set in the same cycle. An rs_done pulse outside the window does nothing.
- R10: A read with rd_en in cycle N gives rd_valid and rd_data in cycle N+1. Addresses 0..3 return the registers, address 4 returns the status word (bit 0 lock, bit 1 window open, other bits zero), and addresses 5..7 return zero. The returned values are those held before any update made at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold power-on reset, asynchronous, active low |
| wr_en | input | 1 | Ordinary write strobe |
| wr_addr | input | 2 | Ordinary write register index |
| wr_be | input | 4 | Byte enables for the ordinary write |
| wr_data | input | 32 | Ordinary write data |
| lock_set | input | 1 | Trusted agent sets the lock |
| pwr_state | input | 3 | Power state: 0 run, 1 sleep, 2 warm reset, 3 hibernate entry, 4 hibernate resume |
| rs_en | input | 1 | Trusted restore write strobe |
| rs_addr | input | 2 | Restore register index |
| rs_data | input | 32 | Restore word |
| rs_lock | input | 1 | Saved lock value applied at restore completion |
| rs_done | input | 1 | Restore complete, closes the window |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Read address: 0..3 registers, 4 status |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data valid |
| viol | output | 1 | One-cycle pulse for each refused write attempt |

## Verification
The bank is driven with directed sequences and with random traffic. The directed runs cover full and partial byte masks, which show that byte merging is correct and not a whole-word overwrite. They also cover writes attempted before and after locking, which show that gating is correct, and a tour through sleep, warm reset and hibernate entry, which shows that nothing is lost on those transitions. Two kinds of hibernate resume are exercised: one ends with rs_done, and one drops the resume code early. They tell apart a window that closes correctly, one that reopens or stays open, and a restore that does or does not bring back the saved lock. The random traffic mixes writes, restores, reads and power codes, and every read and every violation pulse is checked against a model built from the requirements.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  typedef enum logic [2:0] {
    PS_RUN        = 3'd0,
    PS_SLEEP      = 3'd1,
    PS_WARM       = 3'd2,
    PS_HIB_ENTER  = 3'd3,
    PS_HIB_RESUME = 3'd4
  } pwr_state_e;

  localparam int STAT_LOCK_BIT = 0;
  localparam int STAT_WIN_BIT  = 1;
endpackage

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
  import cfg_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rs_en,
  input  logic       rs_done,
  input  logic       rs_lock,
  input  logic       lock_set,
  input  logic [2:0] pwr_state,
  output logic       wr_ok,
  output logic       rs_ok,
  output logic       lock,
  output logic       win,
  output logic       viol
);
  logic       lock_q, lock_d;
  logic       win_q, win_d;
  logic       viol_q, viol_d;
  logic [2:0] ps_q;
  logic       resume_now, resume_edge, done_ok;

  // next-state logic
  always_comb begin
    resume_now  = (pwr_state == PS_HIB_RESUME);
    resume_edge = resume_now && (ps_q != PS_HIB_RESUME);
    done_ok     = win_q && rs_done;
    wr_ok       = wr_en && !lock_q && !win_q;
    rs_ok       = rs_en && win_q;
    win_d       = resume_now && (resume_edge || win_q) && !done_ok;
    lock_d      = (done_ok ? rs_lock : lock_q) | lock_set;
    viol_d      = (wr_en && !wr_ok) || (rs_en && !rs_ok);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      win_q  <= 1'b0;
      viol_q <= 1'b0;
      ps_q   <= PS_RUN;
    end else begin
      lock_q <= lock_d;
      win_q  <= win_d;
      viol_q <= viol_d;
      ps_q   <= pwr_state;
    end
  end

  assign lock = lock_q;
  assign win  = win_q;
  assign viol = viol_q;

  // a set lock stays set unless a restore completes
  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !(win_q && rs_done)) |=> lock_q);

  // the window never opens away from the resume code
  assert_win_only_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_q && (pwr_state != PS_HIB_RESUME)) |=> !win_q);

  // restore completion always closes the window
  assert_done_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && rs_done) |=> !win_q);

  // refused ordinary write is flagged one cycle later
  assert_refused_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (lock_q || win_q)) |=> viol_q);

  // restore completion installs the saved lock value
  assert_restore_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && rs_done && rs_lock) |=> lock_q);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int NREGS = 4,
  parameter int DW    = 32,
  parameter logic [DW-1:0] RST_VAL = '1,
  localparam int AW  = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int BEW = DW / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ok,
  input  logic [AW-1:0]       wr_addr,
  input  logic [BEW-1:0]      wr_be,
  input  logic [DW-1:0]       wr_data,
  input  logic                rs_ok,
  input  logic [AW-1:0]       rs_addr,
  input  logic [DW-1:0]       rs_data,
  output logic [NREGS*DW-1:0] regs_flat
);
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic hit_wr, hit_rs;
    assign hit_wr = wr_ok && (wr_addr == AW'(r));
    assign hit_rs = rs_ok && (rs_addr == AW'(r));
    for (genvar b = 0; b < BEW; b++) begin : g_byte
      logic [7:0] byte_q, byte_d;
      logic       byte_en;
      always_comb begin
        byte_en = hit_rs || (hit_wr && wr_be[b]);
        byte_d  = hit_rs ? rs_data[b*8 +: 8] : wr_data[b*8 +: 8];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       byte_q <= RST_VAL[b*8 +: 8];
        else if (byte_en) byte_q <= byte_d;
      end
      assign regs_flat[r*DW + b*8 +: 8] = byte_q;
    end
  end

  // without a grant the bank keeps its contents
  assert_hold_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ok && !rs_ok) |=> $stable(regs_flat));

  // the controller never grants both paths at once
  assert_grants_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && rs_ok));
endmodule

// File: rtl/cfg_rd_port.sv
module cfg_rd_port
  import cfg_lock_pkg::*;
#(
  parameter int NREGS = 4,
  parameter int DW    = 32,
  parameter int RAW   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [RAW-1:0]      rd_addr,
  input  logic [NREGS*DW-1:0] regs_flat,
  input  logic                lock,
  input  logic                win,
  output logic [DW-1:0]       rd_data,
  output logic                rd_valid
);
  logic [DW-1:0] sel_d, data_q;
  logic          valid_q;

  always_comb begin
    sel_d = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rd_addr == RAW'(i)) sel_d = regs_flat[i*DW +: DW];
    end
    if (rd_addr == RAW'(NREGS)) begin
      sel_d[STAT_LOCK_BIT] = lock;
      sel_d[STAT_WIN_BIT]  = win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en;
      if (rd_en) data_q <= sel_d;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

  assert_read_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_read_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank #(
  parameter int NREGS = 4,
  parameter int DW    = 32,
  localparam int AW  = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int BEW = DW / 8,
  localparam int RAW = $clog2(NREGS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [BEW-1:0] wr_be,
  input  logic [DW-1:0]  wr_data,
  input  logic           lock_set,
  input  logic [2:0]     pwr_state,
  input  logic           rs_en,
  input  logic [AW-1:0]  rs_addr,
  input  logic [DW-1:0]  rs_data,
  input  logic           rs_lock,
  input  logic           rs_done,
  input  logic           rd_en,
  input  logic [RAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid,
  output logic           viol
);
  logic                wr_ok, rs_ok, lock, win;
  logic [NREGS*DW-1:0] regs_flat;

  cfg_lock_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rs_en     (rs_en),
    .rs_done   (rs_done),
    .rs_lock   (rs_lock),
    .lock_set  (lock_set),
    .pwr_state (pwr_state),
    .wr_ok     (wr_ok),
    .rs_ok     (rs_ok),
    .lock      (lock),
    .win       (win),
    .viol      (viol)
  );

  cfg_reg_bank #(.NREGS(NREGS), .DW(DW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ok     (wr_ok),
    .wr_addr   (wr_addr),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .rs_ok     (rs_ok),
    .rs_addr   (rs_addr),
    .rs_data   (rs_data),
    .regs_flat (regs_flat)
  );

  cfg_rd_port #(.NREGS(NREGS), .DW(DW), .RAW(RAW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .regs_flat (regs_flat),
    .lock      (lock),
    .win       (win),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );
endmodule

// File: tb/sim_cfg_lock_bank.sv
`timescale 1ns/1ps
module sim_cfg_lock_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, lock_set, rs_en, rs_lock, rs_done, rd_en;
  logic [1:0]  wr_addr, rs_addr;
  logic [3:0]  wr_be;
  logic [31:0] wr_data, rs_data;
  logic [2:0]  pwr_state, rd_addr;
  logic [31:0] rd_data;
  logic        rd_valid, viol;

  always #2 clk = ~clk;

  cfg_lock_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .lock_set(lock_set), .pwr_state(pwr_state),
    .rs_en(rs_en), .rs_addr(rs_addr), .rs_data(rs_data), .rs_lock(rs_lock),
    .rs_done(rs_done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .viol(viol)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] m_reg [4];
  logic        m_lock, m_win;
  logic [2:0]  m_ps;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old_w, input logic [31:0] new_w, input logic [3:0] be);
    logic [31:0] r = old_w;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] rd_model(input logic [2:0] a);
    if (a < 3'd4) return m_reg[a[1:0]];
    if (a == 3'd4) return {30'd0, m_win, m_lock};
    return 32'd0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_reg[i] = 32'hFFFF_FFFF;
    m_lock = 1'b0; m_win = 1'b0; m_ps = 3'd0;
  endtask

  task automatic idle_inputs();
    wr_en = 0; lock_set = 0; rs_en = 0; rs_lock = 0; rs_done = 0; rd_en = 0;
    wr_addr = 0; rs_addr = 0; wr_be = 0; wr_data = 0; rs_data = 0; rd_addr = 0;
  endtask

  // one clock: model the edge, then compare outputs 1 ns later
  task automatic step(input string tag);
    logic        e_viol, e_rden, done_ok;
    logic [31:0] e_rd;
    @(posedge clk);
    e_viol  = (wr_en && (m_lock || m_win)) || (rs_en && !m_win);
    e_rden  = rd_en;
    e_rd    = rd_model(rd_addr);
    done_ok = m_win && rs_done;
    if (wr_en && !m_lock && !m_win) m_reg[wr_addr] = merge(m_reg[wr_addr], wr_data, wr_be);
    if (rs_en && m_win) m_reg[rs_addr] = rs_data;
    m_lock = (done_ok ? rs_lock : m_lock) | lock_set;
    m_win  = (pwr_state == 3'd4) && ((m_ps != 3'd4) || m_win) && !done_ok;
    m_ps   = pwr_state;
    #1;
    chk(viol == e_viol, {tag, " R4 viol"}, {31'd0, viol}, {31'd0, e_viol});
    if (e_rden) begin
      chk(rd_valid == 1'b1, {tag, " R10 rd_valid"}, {31'd0, rd_valid}, 32'd1);
      chk(rd_data == e_rd, {tag, " read"}, rd_data, e_rd);
    end
    idle_inputs();
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be, input string tag);
    wr_en = 1; wr_addr = a; wr_data = d; wr_be = be; step(tag);
  endtask
  task automatic do_rd(input logic [2:0] a, input string tag);
    rd_en = 1; rd_addr = a; step(tag);
  endtask
  task automatic do_rs(input logic [1:0] a, input logic [31:0] d, input string tag);
    rs_en = 1; rs_addr = a; rs_data = d; step(tag);
  endtask
  task automatic read_all(input string tag);
    for (int a = 0; a < 5; a++) do_rd(3'(a), tag);
  endtask

  task automatic cold_reset();
    rst_n = 0; idle_inputs(); pwr_state = 3'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    model_reset();
  endtask

  task automatic random_phase(input int n, input bit wide, input string tag);
    for (int i = 0; i < n; i++) begin
      int k = $urandom_range(0, 99);
      if (k < 30) begin
        wr_en = 1; wr_addr = 2'($urandom_range(0, 3));
        wr_data = $urandom(); wr_be = 4'($urandom_range(0, 15));
      end
      if (k >= 30 && k < 60) begin rd_en = 1; rd_addr = 3'($urandom_range(0, 7)); end
      if (wide && k >= 60 && k < 72) begin
        rs_en = 1; rs_addr = 2'($urandom_range(0, 3)); rs_data = $urandom();
      end
      if (wide && k >= 72 && k < 76) begin rs_done = 1; rs_lock = 1'($urandom_range(0, 1)); end
      if (wide && k == 76) lock_set = 1;
      if ($urandom_range(0, 9) == 0)
        pwr_state = 3'($urandom_range(0, wide ? 4 : 3));
      step(tag);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    idle_inputs(); pwr_state = 3'd0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    model_reset();
    // R1 reset state
    chk(rd_valid == 1'b0, "R1 rd_valid at reset", {31'd0, rd_valid}, 32'd0);
    chk(viol == 1'b0, "R1 viol at reset", {31'd0, viol}, 32'd0);
    read_all("R1 reset contents");
    // R2 full and partial byte writes
    do_wr(2'd1, 32'h1234_5678, 4'b1111, "R2 full");
    do_rd(3'd1, "R2 full readback");
    do_wr(2'd1, 32'hAABB_CCDD, 4'b0101, "R2 partial");
    do_rd(3'd1, "R2 partial readback");
    chk(m_reg[1] == 32'h12BB_56DD, "R2 merge model", m_reg[1], 32'h12BB_56DD);
    random_phase(200, 1'b0, "R6 unlocked random");
    pwr_state = 3'd0; step("idle");
    // R3 lock then refuse writes
    lock_set = 1; step("R3 lock set");
    do_rd(3'd4, "R3 status locked");
    do_wr(2'd0, 32'h0, 4'hF, "R3 refused write");
    do_wr(2'd2, 32'h5555_5555, 4'h3, "R3 refused partial");
    read_all("R3 contents held");
    // R6 retention through power codes, R5 lock held
    for (int p = 1; p < 4; p++) begin
      pwr_state = 3'(p);
      do_wr(2'(p), 32'hDEAD_BEEF, 4'hF, "R5 write in low power");
      do_rd(3'd4, "R6 status in low power");
    end
    pwr_state = 3'd0;
    read_all("R6 contents after transitions");
    // R8 restore outside window refused
    do_rs(2'd3, 32'h0BAD_0BAD, "R8 restore outside window");
    do_rd(3'd3, "R8 unchanged");
    // R7 hibernate resume window
    pwr_state = 3'd4; step("R7 enter resume");
    do_rd(3'd4, "R7 status window open");
    do_wr(2'd0, 32'h1, 4'hF, "R4 write in window");
    for (int a = 0; a < 4; a++) do_rs(2'(a), 32'hC0DE_0000 + 32'(a), "R8 restore write");
    rs_done = 1; rs_lock = 1; step("R9 restore done");
    do_rd(3'd4, "R9 status after restore");
    read_all("R8 restored contents");
    do_rd(3'd4, "R7 window not reopened");
    pwr_state = 3'd0; step("idle");
    // R5 only cold reset clears lock
    cold_reset();
    read_all("R1 after cold reset");
    // R7 leaving resume closes window
    pwr_state = 3'd4; step("R7 resume again");
    pwr_state = 3'd0; step("R7 leave resume");
    do_rd(3'd4, "R7 window closed");
    do_rs(2'd0, 32'h0, "R8 restore after close");
    // R9 restore can install lock
    pwr_state = 3'd4; step("R9 resume");
    rs_done = 1; rs_lock = 1; step("R9 done lock");
    do_rd(3'd4, "R9 lock installed");
    do_rd(3'd5, "R10 unused address");
    do_rd(3'd7, "R10 unused address");
    pwr_state = 3'd0; step("idle");
    cold_reset();
    random_phase(600, 1'b1, "R9 mixed random");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule